// File: doc/BRIEF.md
# Debug Halt and Step Controller

This block decides when an in-order processor core must stop for debugging and when it may go on. It sits beside the core and sees three kinds of event: the core asking to start its next instruction, an instruction retiring, and data words moving over the core's bus. From these it grants or withholds each instruction start. It raises a halt request when a breakpoint fires or a single step has finished, and it resumes the core when the debug port sends a one-cycle GO pulse.

A data breakpoint compares each bus data word with a stored 32-bit pattern under a 32-bit mask. A set mask bit removes that bit from the comparison. Control bits select single-step mode, suppression of interrupt requests while stepping, and a non-pipelined mode. In pipelined mode a data trigger is reported a fixed two cycles late. In non-pipelined mode each instruction start waits until the previous instruction has retired, and a data trigger is reported in the same cycle, so the next start is never granted. A program-counter hit, flagged by an external comparator together with the start request, always stops the core before that instruction starts. All registers are loaded through a simple indexed write port.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the core is running (`halted`=0), `halt_cause`=0, the pattern, mask and control registers hold zero, and no data trigger can fire.
- R2: A write with `cfg_we`=1 loads the pattern at index 0x0E, the mask at index 0x0F and the control word at index 0x07. Control bit 0 enables the data breakpoint, bit 1 selects single-step, bit 2 blocks interrupts while stepping, and bit 3 selects non-pipelined mode.
- R3: A data match occurs when the breakpoint is enabled, `bus_valid`=1, and `bus_data` equals the pattern in every bit whose mask bit is 0. Bits with mask 1 are ignored.
- R4: In pipelined mode a data match seen in cycle T drives `halt_req` high in cycle T+2. It is not high in T+1, and instruction starts are still granted in T+1.
- R5: In non-pipelined mode a data match drives `halt_req` high in the same cycle, and `start_gnt` is 0 in that cycle.
- R6: In non-pipelined mode no start is granted while an earlier granted instruction has not yet retired.
- R7: When `start_req` and `pc_hit` are both 1 while running, `start_gnt` is 0 and `halt_req` is 1 in that cycle.
- R8: `halt_req` makes `halted` 1 from the next cycle. While halted, `start_gnt` and `halt_req` stay 0.
- R9: With single-step set, a GO pulse while halted allows exactly one grant. The retire of that instruction raises `halt_req`, and the core halts again with cause step.
- R10: A GO pulse while running has no effect. A GO pulse while halted clears `halted` on the next cycle. With single-step clear, starts are then granted freely.
- R11: `irq_out` follows `irq_in`, except that it is 0 while single-step and the interrupt-block bit are both set.
- R12: `halt_cause` is captured on each halt as 1 = PC hit, 2 = data, 3 = step, with priority PC over data over step. It holds its value until the next halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Debug register index |
| cfg_wdata | input | 32 | Register write data |
| start_req | input | 1 | Core requests to start its next instruction |
| pc_hit | input | 1 | Program-counter breakpoint hit on the requested instruction |
| start_gnt | output | 1 | Instruction start granted |
| retire | input | 1 | An instruction has fully completed |
| bus_valid | input | 1 | A data transfer occurs this cycle |
| bus_data | input | 32 | Data word of the transfer |
| irq_in | input | 1 | Interrupt request towards the core |
| irq_out | output | 1 | Interrupt request passed to the core |
| go | input | 1 | One-cycle resume pulse from the debug port |
| halt_req | output | 1 | Halt request this cycle |
| halted | output | 1 | Core is held halted |
| halt_cause | output | 2 | Cause of the latest halt |

## Verification
A data trigger and the end of a single step can land in the same cycle. The bench sets up non-pipelined stepping, grants the one stepped instruction, and then presents a matching bus word together with that instruction's retire. It expects one `halt_req` pulse, and it expects `halt_cause` to read data rather than step. A program-counter hit arriving together with a pipelined data trigger is also provoked, and the cause must read PC.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PC   = 2'd1,
    CAUSE_DATA = 2'd2,
    CAUSE_STEP = 2'd3
  } halt_cause_e;

  typedef struct packed {
    logic nonpipe;
    logic irq_block;
    logic step;
    logic dbp_en;
  } dbg_ctrl_t;

  function automatic logic masked_equal(input logic [DATA_W-1:0] value,
                                        input logic [DATA_W-1:0] pattern,
                                        input logic [DATA_W-1:0] mask);
    return ((value ^ pattern) & ~mask) == '0;
  endfunction

  function automatic halt_cause_e pick_cause(input logic pc, input logic data,
                                             input logic step);
    if (pc)        return CAUSE_PC;
    else if (data) return CAUSE_DATA;
    else if (step) return CAUSE_STEP;
    else           return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_halt_pkg::*;
#(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_IDX = 14,
  parameter int unsigned MASK_IDX = 15,
  parameter int unsigned CTRL_IDX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bp_data,
  output logic [DATA_W-1:0] bp_mask,
  output dbg_ctrl_t         ctrl
);

  localparam int unsigned CTRL_W = $bits(dbg_ctrl_t);

  logic hit_data, hit_mask, hit_ctrl;

  assign hit_data = we && (idx == IDX_W'(DATA_IDX));
  assign hit_mask = we && (idx == IDX_W'(MASK_IDX));
  assign hit_ctrl = we && (idx == IDX_W'(CTRL_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_data <= '0;
      bp_mask <= '0;
      ctrl    <= '0;
    end else begin
      if (hit_data) bp_data <= wdata;
      if (hit_mask) bp_mask <= wdata;
      if (hit_ctrl) ctrl    <= dbg_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

endmodule

// File: rtl/dbg_data_trig.sv
module dbg_data_trig
  import dbg_halt_pkg::*;
#(
  parameter int unsigned TRIG_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              enable,
  input  logic              nonpipe,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] bp_data,
  input  logic [DATA_W-1:0] bp_mask,
  output logic              match_now,
  output logic              data_halt
);

  logic pipe_in;
  logic pipe_out;

  assign match_now = running && enable && bus_valid &&
                     masked_equal(bus_data, bp_data, bp_mask);
  assign pipe_in   = match_now && !nonpipe;

  generate
    if (TRIG_DLY == 0) begin : g_nodly
      assign pipe_out = pipe_in;
    end else begin : g_dly
      logic [TRIG_DLY-1:0] stage;
      always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
          stage <= '0;
        end else begin
          stage[0] <= pipe_in;
          for (int i = 1; i < int'(TRIG_DLY); i++) stage[i] <= stage[i-1];
        end
      end
      assign pipe_out = stage[TRIG_DLY-1];
    end
  endgenerate

  assign data_halt = nonpipe ? match_now : (pipe_out && running);

endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_halt_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             pc_hit,
  input  logic             retire,
  input  logic             go,
  input  logic             step_mode,
  input  logic             nonpipe,
  input  logic             data_halt,
  output logic             start_gnt,
  output logic             halt_req,
  output logic             halted,
  output halt_cause_e      halt_cause,
  output logic [CNT_W-1:0] outst_cnt,
  output logic             step_used
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic running;
  logic pc_trig;
  logic step_done;
  logic np_busy;
  logic cnt_up, cnt_dn;

  assign running   = !halted;
  assign pc_trig   = running && start_req && pc_hit;
  assign step_done = running && step_used && retire;
  assign halt_req  = running && (pc_trig || data_halt || step_done);
  assign np_busy   = nonpipe && (outst_cnt != '0);

  assign start_gnt = running && start_req && !halt_req && !np_busy && !step_used;

  assign cnt_up = start_gnt && (outst_cnt != CNT_MAX);
  assign cnt_dn = retire && (outst_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted     <= 1'b0;
      halt_cause <= CAUSE_NONE;
      step_used  <= 1'b0;
      outst_cnt  <= '0;
    end else begin
      if (halt_req) begin
        halted     <= 1'b1;
        halt_cause <= pick_cause(pc_trig, data_halt, step_done);
      end else if (halted && go) begin
        halted <= 1'b0;
      end

      if (halted || halt_req)          step_used <= 1'b0;
      else if (start_gnt && step_mode) step_used <= 1'b1;

      if (cnt_up && !cnt_dn)      outst_cnt <= outst_cnt + 1'b1;
      else if (cnt_dn && !cnt_up) outst_cnt <= outst_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_IDX = 14,
  parameter int unsigned MASK_IDX = 15,
  parameter int unsigned CTRL_IDX = 7,
  parameter int unsigned TRIG_DLY = 2,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              start_req,
  input  logic              pc_hit,
  output logic              start_gnt,
  input  logic              retire,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              irq_in,
  output logic              irq_out,
  input  logic              go,
  output logic              halt_req,
  output logic              halted,
  output logic [1:0]        halt_cause
);

  logic [DATA_W-1:0] bp_data, bp_mask;
  dbg_ctrl_t         ctl;
  logic              match_now, data_halt;
  logic [CNT_W-1:0]  outst_cnt;
  logic              step_used;
  halt_cause_e       cause_q;

  dbg_regs #(
    .IDX_W(IDX_W), .DATA_IDX(DATA_IDX), .MASK_IDX(MASK_IDX), .CTRL_IDX(CTRL_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .bp_data(bp_data), .bp_mask(bp_mask), .ctrl(ctl)
  );

  dbg_data_trig #(.TRIG_DLY(TRIG_DLY)) u_trig (
    .clk(clk), .rst_n(rst_n), .running(!halted), .enable(ctl.dbp_en),
    .nonpipe(ctl.nonpipe), .bus_valid(bus_valid), .bus_data(bus_data),
    .bp_data(bp_data), .bp_mask(bp_mask),
    .match_now(match_now), .data_halt(data_halt)
  );

  dbg_run_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pc_hit(pc_hit),
    .retire(retire), .go(go), .step_mode(ctl.step), .nonpipe(ctl.nonpipe),
    .data_halt(data_halt), .start_gnt(start_gnt), .halt_req(halt_req),
    .halted(halted), .halt_cause(cause_q), .outst_cnt(outst_cnt),
    .step_used(step_used)
  );

  assign halt_cause = cause_q;
  assign irq_out    = irq_in && !(ctl.step && ctl.irq_block);

endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             pc_hit,
  input logic             start_gnt,
  input logic             go,
  input logic             halt_req,
  input logic             halted,
  input logic [1:0]       halt_cause,
  input logic             irq_out,
  input logic             ctl_step,
  input logic             ctl_irq_block,
  input logic             ctl_nonpipe,
  input logic [CNT_W-1:0] outst_cnt
);

  AST_HALT_THEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halted); // R8

  AST_NO_GNT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!start_gnt && !halt_req)); // R8

  AST_PC_BLOCKS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && pc_hit && !halted) |-> (!start_gnt && halt_req)); // R7

  AST_STEP_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_step && start_gnt) |=> !start_gnt); // R9

  AST_GO_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && go) |=> !halted); // R10

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_step && ctl_irq_block) |-> !irq_out); // R11

  AST_NP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_nonpipe && outst_cnt != '0) |-> !start_gnt); // R6

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !go) |=> (halted && $stable(halt_cause))); // R12

endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .pc_hit(pc_hit),
  .start_gnt(start_gnt), .go(go), .halt_req(halt_req), .halted(halted),
  .halt_cause(halt_cause), .irq_out(irq_out), .ctl_step(ctl.step),
  .ctl_irq_block(ctl.irq_block), .ctl_nonpipe(ctl.nonpipe),
  .outst_cnt(outst_cnt)
);

// File: tb/dbg_halt_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        start_req, pc_hit, start_gnt, retire, bus_valid;
  logic [31:0] bus_data;
  logic        irq_in, irq_out, go, halt_req, halted;
  logic [1:0]  halt_cause;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .start_req(start_req), .pc_hit(pc_hit),
    .start_gnt(start_gnt), .retire(retire), .bus_valid(bus_valid),
    .bus_data(bus_data), .irq_in(irq_in), .irq_out(irq_out), .go(go),
    .halt_req(halt_req), .halted(halted), .halt_cause(halt_cause)
  );

  localparam logic [3:0] C_EN = 4'b0001, C_STEP = 4'b0010,
                         C_IRQB = 4'b0100, C_NP = 4'b1000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // advance to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_go();
    go = 1'b1;
    tick();
    go = 1'b0;
  endtask

  function automatic bit exp_match(input logic [31:0] v, input logic [31:0] d,
                                   input logic [31:0] m);
    for (int b = 0; b < 32; b++)
      if (!m[b] && (v[b] != d[b])) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat, msk;
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
    start_req = 0; pc_hit = 0; retire = 0; bus_valid = 0; bus_data = 0;
    irq_in = 0; go = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state; zero bus word equals zero pattern but enable is clear
    eq("R1 halted", halted, 0);
    eq("R1 cause", halt_cause, 0);
    bus_valid = 1; bus_data = 0;
    repeat (3) begin #2; eq("R1 no trigger", halt_req, 0); tick(); end
    bus_valid = 0;

    // R11 interrupt gating, all four combinations of step and block
    irq_in = 1;
    for (int k = 0; k < 4; k++) begin
      wr(5'h07, {28'd0, k[1] ? C_IRQB : 4'd0} | (k[0] ? C_STEP : 4'd0));
      #1;
      eq("R11 irq", irq_out, (k == 3) ? 0 : 1);
    end
    irq_in = 0;
    wr(5'h07, 0);
    tick();

    // R2 R3 R5 masked sweep in non-pipelined mode
    pat = 32'h5A3C_96E1; msk = 32'hF000_000C;
    wr(5'h0E, pat);
    wr(5'h0F, msk);
    wr(5'h07, {28'd0, C_EN | C_NP});
    for (int i = 0; i < 256; i++) begin
      logic [31:0] v;
      bit e;
      v = pat ^ {i[7:4], 24'd0, i[3:0]};
      e = exp_match(v, pat, msk);
      bus_valid = 1; bus_data = v; start_req = 1;
      #2;
      eq("R3 R5 match", halt_req, e);
      eq("R5 gnt", start_gnt, !e);
      tick();
      bus_valid = 0; start_req = 0;
      if (e) begin
        eq("R8 halted", halted, 1);
        eq("R12 cause data", halt_cause, 2);
        pulse_go();
        eq("R10 resumed", halted, 0);
      end else begin
        retire = 1; tick(); retire = 0;
      end
    end

    // R2 write to another index leaves pattern untouched
    wr(5'h0D, 32'hFFFF_FFFF);
    bus_valid = 1; bus_data = pat; #2;
    eq("R2 pattern kept", halt_req, 1);
    tick(); bus_valid = 0;
    pulse_go();

    // R6 non-pipelined: one outstanding instruction
    start_req = 1; #2;
    eq("R6 first gnt", start_gnt, 1);
    tick(); #2;
    eq("R6 blocked", start_gnt, 0);
    tick(); retire = 1; #2;
    eq("R6 blocked at retire", start_gnt, 0);
    tick(); retire = 0; #2;
    eq("R6 gnt after retire", start_gnt, 1);
    tick(); start_req = 0;
    retire = 1; tick(); retire = 0;

    // R4 pipelined timing
    wr(5'h07, {28'd0, C_EN});
    start_req = 1; bus_valid = 1; bus_data = pat; #2;
    eq("R4 T0 no halt", halt_req, 0);
    tick(); bus_valid = 0; #2;
    eq("R4 T1 no halt", halt_req, 0);
    eq("R4 T1 gnt", start_gnt, 1);
    tick(); #2;
    eq("R4 T2 halt", halt_req, 1);
    eq("R4 T2 gnt", start_gnt, 0);
    tick(); start_req = 0;
    eq("R4 halted", halted, 1);
    eq("R12 cause data", halt_cause, 2);
    retire = 1; repeat (2) tick(); retire = 0;

    // R10 go while running ignored
    pulse_go();
    eq("R10 go halted", halted, 0);
    pulse_go();
    eq("R10 go running", halted, 0);
    eq("R10 cause kept", halt_cause, 2);

    // R7 R12 pc hit together with pipelined data trigger: PC wins
    bus_valid = 1; bus_data = pat; tick(); bus_valid = 0; tick();
    start_req = 1; pc_hit = 1; #2;
    eq("R7 halt", halt_req, 1);
    eq("R7 gnt", start_gnt, 0);
    tick(); pc_hit = 0; start_req = 0;
    eq("R12 cause pc", halt_cause, 1);
    repeat (2) tick();
    eq("R12 cause held", halt_cause, 1);
    eq("R8 still halted", halted, 1);

    // R9 single-step from halt
    wr(5'h07, {28'd0, C_STEP});
    start_req = 1; #2;
    eq("R8 no gnt halted", start_gnt, 0);
    start_req = 0;
    for (int s = 0; s < 2; s++) begin
      pulse_go();
      start_req = 1; #2;
      eq("R9 one gnt", start_gnt, 1);
      tick(); #2;
      eq("R9 no second gnt", start_gnt, 0);
      tick(); retire = 1; #2;
      eq("R9 halt at retire", halt_req, 1);
      tick(); retire = 0; start_req = 0;
      eq("R9 halted", halted, 1);
      eq("R12 cause step", halt_cause, 3);
    end

    // R12 step end coinciding with non-pipelined data match: data wins
    wr(5'h07, {28'd0, C_STEP | C_EN | C_NP});
    pulse_go();
    start_req = 1; #2;
    eq("R9 np step gnt", start_gnt, 1);
    tick(); start_req = 0;
    retire = 1; bus_valid = 1; bus_data = pat; #2;
    eq("R12 single halt", halt_req, 1);
    tick(); retire = 0; bus_valid = 0;
    eq("R12 cause data over step", halt_cause, 2);

    // R10 go with step clear: free running
    wr(5'h07, 0);
    pulse_go();
    start_req = 1;
    for (int j = 0; j < 4; j++) begin
      #2; eq("R10 free run gnt", start_gnt, 1);
      tick();
    end
    start_req = 0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule